// File: doc/BRIEF.md
# Comparator Output Conditioner with Edge Interrupts

This block takes the single-bit output of an analog comparator, which arrives asynchronously, and turns it into a clean filtered level plus an interrupt request. The raw bit first passes through a two-flop synchronizer. It is then sampled once every `filt_per` bus clocks. A consecutive-match filter can require `filt_cnt` samples in a row that all disagree with the present output before that output flips. A window input can hold the sampling still at any time.

Changes of the filtered level set sticky rising and falling flags. Each flag has its own enable bit. The enabled flags are combined into one registered interrupt request. Software changes the enables and clears the flags through a small write port. Each filter setting has a fixed worst-case latency in clock cycles, so firmware can trade noise rejection against response time.

Top module: `cmp_edge_filter`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `cmp_filt`, `flag_rise`, `flag_fall`, `en_rise`, `en_fall` and `irq` are all 0, and the filter counters are cleared.
- R2: When `filt_cnt` is 0 the filter is bypassed and ignores both `win_en` and `filt_per`. `cmp_filt` then equals the value `cmp_raw` had three clock edges earlier: two synchronizer stages plus the output register.
- R3: When `filt_cnt` is 1, `cmp_filt` takes the synchronized input only on a sample tick. A tick occurs once every `filt_per` clocks while `win_en` is high. A `filt_per` of 0 acts as 1.
- R4: When `filt_cnt` is not 0 and `win_en` is low, the sample counter and `cmp_filt` hold their values.
- R5: When `filt_cnt` is greater than 1, `cmp_filt` flips only after `filt_cnt` consecutive samples that all differ from it. A sample equal to `cmp_filt` restarts the run.
- R6: One clock after `cmp_filt` rises, `flag_rise` is 1. One clock after `cmp_filt` falls, `flag_fall` is 1. Both flags stay set until they are cleared.
- R7: A write with `reg_sel`=1 clears `flag_rise` where `reg_wdata[0]` is 1 and clears `flag_fall` where `reg_wdata[1]` is 1. Bits written as 0 have no effect. An edge that arrives in the same cycle as its clear keeps the flag set.
- R8: A write with `reg_sel`=0 loads `en_rise` from `reg_wdata[0]` and `en_fall` from `reg_wdata[1]`.
- R9: `irq` is 1 exactly when (`en_rise` and `flag_rise`) or (`en_fall` and `flag_fall`) hold. It is updated in the same cycle as the flags and enables.
- R10: With `win_en` held high, a change of `cmp_raw` reaches `cmp_filt` within `filt_per`+2 clocks when `filt_cnt` is 1, and within `filt_cnt`×`filt_per`+2 clocks when `filt_cnt` is greater than 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_raw | input | 1 | Asynchronous comparator output |
| win_en | input | 1 | Sampling window; low freezes the filter |
| filt_per | input | PER_W | Sample period in clocks (0 acts as 1) |
| filt_cnt | input | CNT_W | Consecutive-sample count; 0 bypasses the filter |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = enable register, 1 = flag clear (write 1 to clear) |
| reg_wdata | input | 2 | Bit 0 selects the rising edge, bit 1 the falling edge |
| cmp_filt | output | 1 | Filtered comparator level |
| flag_rise | output | 1 | Sticky rising-edge flag |
| flag_fall | output | 1 | Sticky falling-edge flag |
| en_rise | output | 1 | Rising-edge interrupt enable |
| en_fall | output | 1 | Falling-edge interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several properties on every cycle. The filtered level changes only on a sample tick, and it stays frozen while the window is closed. Each filtered edge raises its flag on the next clock. A clear with no competing edge drops its flag, and the request agrees with the flags and enables. Some behaviour only the bench scenarios can show. These are the three-cycle bypass delay, the rejection of glitches shorter than the sample run, and the worst-case latency bounds for each setting. The same-cycle contest between a clear and a new edge also needs a directed scenario. A behavioural model, compared on every clock through randomized stretches, covers everything else.

// File: rtl/cmpf_pkg.sv
package cmpf_pkg;
  localparam logic SEL_ENABLE = 1'b0;
  localparam logic SEL_FLAGS  = 1'b1;
  localparam int   EDGE_RISE  = 0;
  localparam int   EDGE_FALL  = 1;

  typedef struct packed {
    logic fall;
    logic rise;
  } edge_pair_t;
endpackage

// File: rtl/cmpf_sync.sv
module cmpf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/cmpf_sampler.sv
module cmpf_sampler #(
  parameter int PER_W = 8,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic             win_en,
  input  logic [PER_W-1:0] filt_per,
  input  logic [CNT_W-1:0] filt_cnt,
  output logic             dout
);
  logic [PER_W-1:0] per_cnt;
  logic [PER_W-1:0] per_limit;
  logic [CNT_W-1:0] run_cnt;
  logic [CNT_W:0]   run_next;
  logic             bypass;
  logic             tick;
  logic             filt_q;

  assign bypass    = (filt_cnt == '0);
  assign per_limit = (filt_per == '0) ? PER_W'(1) : filt_per;
  assign tick      = !bypass && win_en && (per_cnt >= per_limit - PER_W'(1));
  assign run_next  = {1'b0, run_cnt} + (CNT_W+1)'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      per_cnt <= '0;
      run_cnt <= '0;
      filt_q  <= 1'b0;
    end else if (bypass) begin
      per_cnt <= '0;
      run_cnt <= '0;
      filt_q  <= din;
    end else if (win_en) begin
      per_cnt <= tick ? '0 : per_cnt + PER_W'(1);
      if (tick) begin
        if (din == filt_q) begin
          run_cnt <= '0;
        end else if (run_next >= {1'b0, filt_cnt}) begin
          filt_q  <= din;
          run_cnt <= '0;
        end else begin
          run_cnt <= run_next[CNT_W-1:0];
        end
      end
    end
  end

  assign dout = filt_q;

  // R3: in filtered modes the level moves only on a sample tick
  assert_change_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
    ((filt_q != $past(filt_q)) && !$past(bypass)) |-> $past(tick));

  // R4: closed window freezes the sample counter
  assert_counter_frozen_R4: assert property (@(posedge clk) disable iff (rst)
    (!win_en && !bypass) |=> $stable(per_cnt));
endmodule

// File: rtl/cmpf_irq.sv
module cmpf_irq
  import cmpf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       level,
  input  logic       reg_we,
  input  logic       reg_sel,
  input  logic [1:0] reg_wdata,
  output edge_pair_t flags,
  output edge_pair_t enables,
  output logic       irq
);
  logic       level_prev;
  edge_pair_t evt;
  edge_pair_t clr;
  edge_pair_t flags_n;
  edge_pair_t enables_n;
  logic       irq_q;

  assign evt.rise = level && !level_prev;
  assign evt.fall = !level && level_prev;

  assign clr.rise = reg_we && (reg_sel == SEL_FLAGS) && reg_wdata[EDGE_RISE];
  assign clr.fall = reg_we && (reg_sel == SEL_FLAGS) && reg_wdata[EDGE_FALL];

  always_comb begin
    flags_n.rise = evt.rise || (flags.rise && !clr.rise);
    flags_n.fall = evt.fall || (flags.fall && !clr.fall);
    enables_n    = enables;
    if (reg_we && (reg_sel == SEL_ENABLE)) begin
      enables_n.rise = reg_wdata[EDGE_RISE];
      enables_n.fall = reg_wdata[EDGE_FALL];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_prev <= 1'b0;
      flags      <= '0;
      enables    <= '0;
      irq_q      <= 1'b0;
    end else begin
      level_prev <= level;
      flags      <= flags_n;
      enables    <= enables_n;
      irq_q      <= (flags_n.rise && enables_n.rise) || (flags_n.fall && enables_n.fall);
    end
  end

  assign irq = irq_q;

  // R6: a detected edge sets its flag on the next clock
  assert_rise_sets_flag_R6: assert property (@(posedge clk) disable iff (rst)
    evt.rise |=> flags.rise);
  assert_fall_sets_flag_R6: assert property (@(posedge clk) disable iff (rst)
    evt.fall |=> flags.fall);

  // R7: a clear without a competing edge drops the flag
  assert_clear_rise_R7: assert property (@(posedge clk) disable iff (rst)
    (clr.rise && !evt.rise) |=> !flags.rise);
  assert_clear_fall_R7: assert property (@(posedge clk) disable iff (rst)
    (clr.fall && !evt.fall) |=> !flags.fall);
endmodule

// File: rtl/cmp_edge_filter.sv
module cmp_edge_filter
  import cmpf_pkg::*;
#(
  parameter int PER_W     = 8,
  parameter int CNT_W     = 3,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_raw,
  input  logic             win_en,
  input  logic [PER_W-1:0] filt_per,
  input  logic [CNT_W-1:0] filt_cnt,
  input  logic             reg_we,
  input  logic             reg_sel,
  input  logic [1:0]       reg_wdata,
  output logic             cmp_filt,
  output logic             flag_rise,
  output logic             flag_fall,
  output logic             en_rise,
  output logic             en_fall,
  output logic             irq
);
  logic       raw_sync;
  logic       level;
  edge_pair_t flags;
  edge_pair_t enables;

  cmpf_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (cmp_raw),
    .q_sync  (raw_sync)
  );

  cmpf_sampler #(.PER_W(PER_W), .CNT_W(CNT_W)) u_sampler (
    .clk      (clk),
    .rst      (rst),
    .din      (raw_sync),
    .win_en   (win_en),
    .filt_per (filt_per),
    .filt_cnt (filt_cnt),
    .dout     (level)
  );

  cmpf_irq u_irq (
    .clk       (clk),
    .rst       (rst),
    .level     (level),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .flags     (flags),
    .enables   (enables),
    .irq       (irq)
  );

  assign cmp_filt  = level;
  assign flag_rise = flags.rise;
  assign flag_fall = flags.fall;
  assign en_rise   = enables.rise;
  assign en_fall   = enables.fall;

  // R4: closed window holds the filtered level
  assert_window_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!win_en && (filt_cnt != '0)) |=> $stable(cmp_filt));

  // R9: no request without an enabled, set flag
  assert_irq_needs_source_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> ((flag_rise && en_rise) || (flag_fall && en_fall)));

  // R1: first cycle out of reset is quiet
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $fell(rst) |-> (!cmp_filt && !flag_rise && !flag_fall && !irq));
endmodule

// File: tb/cmp_edge_filter_tb_top.sv
module cmp_edge_filter_tb_top;
  localparam int PER_W = 8;
  localparam int CNT_W = 3;

  logic             clk = 1'b0;
  logic             rst;
  logic             cmp_raw;
  logic             win_en;
  logic [PER_W-1:0] filt_per;
  logic [CNT_W-1:0] filt_cnt;
  logic             reg_we;
  logic             reg_sel;
  logic [1:0]       reg_wdata;
  logic             cmp_filt, flag_rise, flag_fall, en_rise, en_fall, irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  cmp_edge_filter #(.PER_W(PER_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .cmp_raw(cmp_raw), .win_en(win_en),
    .filt_per(filt_per), .filt_cnt(filt_cnt), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .cmp_filt(cmp_filt),
    .flag_rise(flag_rise), .flag_fall(flag_fall), .en_rise(en_rise),
    .en_fall(en_fall), .irq(irq)
  );

  // behavioural reference model
  int m_sh[$];
  int m_pc, m_run, m_lvl, m_prev, m_fr, m_ff, m_er, m_ef, m_irq;

  always @(posedge clk) begin
    int d, lim, nfr, nff, ner, nef;
    if (rst) begin
      m_sh = '{0, 0};
      m_pc = 0; m_run = 0; m_lvl = 0; m_prev = 0;
      m_fr = 0; m_ff = 0; m_er = 0; m_ef = 0; m_irq = 0;
    end else begin
      d   = m_sh[0];
      nfr = (m_lvl == 1 && m_prev == 0) || (m_fr == 1 && !(reg_we && reg_sel && reg_wdata[0]));
      nff = (m_lvl == 0 && m_prev == 1) || (m_ff == 1 && !(reg_we && reg_sel && reg_wdata[1]));
      ner = m_er; nef = m_ef;
      if (reg_we && !reg_sel) begin ner = reg_wdata[0]; nef = reg_wdata[1]; end
      m_irq = (nfr && ner) || (nff && nef);
      m_prev = m_lvl;
      m_fr = nfr; m_ff = nff; m_er = ner; m_ef = nef;
      if (filt_cnt == 0) begin
        m_pc = 0; m_run = 0; m_lvl = d;
      end else if (win_en) begin
        lim = (filt_per == 0) ? 1 : int'(filt_per);
        if (m_pc >= lim - 1) begin
          m_pc = 0;
          if (d == m_lvl) m_run = 0;
          else if (m_run + 1 >= int'(filt_cnt)) begin m_lvl = d; m_run = 0; end
          else m_run = m_run + 1;
        end else m_pc = m_pc + 1;
      end
      void'(m_sh.pop_front());
      m_sh.push_back(int'(cmp_raw));
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // compare against the model on every falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(int'(cmp_filt) == m_lvl, "R3 model cmp_filt", cmp_filt, m_lvl);
      check(int'(flag_rise) == m_fr && int'(flag_fall) == m_ff, "R6 model flags",
            {flag_fall, flag_rise}, m_ff * 2 + m_fr);
      check(int'(en_rise) == m_er && int'(en_fall) == m_ef, "R8 model enables",
            {en_fall, en_rise}, m_ef * 2 + m_er);
      check(int'(irq) == m_irq, "R9 model irq", irq, m_irq);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [1:0] d);
    reg_we = 1; reg_sel = sel; reg_wdata = d;
    cyc(1);
    reg_we = 0; reg_wdata = 0;
  endtask

  // drive raw to v and count clocks until cmp_filt follows
  task automatic latency(input logic v, input int bound, input string req);
    int n = 0;
    cmp_raw = v;
    while (cmp_filt != v && n < bound + 5) begin cyc(1); n++; end
    check(n <= bound && cmp_filt == v, req, n, bound);
  endtask

  initial begin
    rst = 1; cmp_raw = 0; win_en = 1; filt_per = 8'd1; filt_cnt = 3'd0;
    reg_we = 0; reg_sel = 0; reg_wdata = 0;
    cyc(3);
    check({cmp_filt, flag_rise, flag_fall, en_rise, en_fall, irq} == 6'b0, "R1 reset outputs",
          {cmp_filt, flag_rise, flag_fall, en_rise, en_fall, irq}, 0);
    rst = 0;
    cyc(1);
    check({cmp_filt, flag_rise, flag_fall, irq} == 4'b0, "R1 after release",
          {cmp_filt, flag_rise, flag_fall, irq}, 0);

    // R2 bypass: three-edge delay, window ignored
    win_en = 0; filt_per = 8'd50;
    cmp_raw = 1;
    cyc(2);
    check(cmp_filt == 0, "R2 bypass not yet", cmp_filt, 0);
    cyc(1);
    check(cmp_filt == 1, "R2 bypass third edge", cmp_filt, 1);
    cyc(1);
    check(flag_rise == 1, "R6 rise flag", flag_rise, 1);
    win_en = 1;

    // R8 enables, R9 request
    wr(1'b0, 2'b11);
    check(en_rise && en_fall, "R8 enables loaded", {en_fall, en_rise}, 3);
    check(irq == 1, "R9 irq with rise flag", irq, 1);

    // R7 write 0 no effect, write 1 clears
    wr(1'b1, 2'b00);
    check(flag_rise == 1, "R7 zero write keeps flag", flag_rise, 1);
    wr(1'b1, 2'b01);
    check(flag_rise == 0, "R7 clear rise", flag_rise, 0);
    check(irq == 0, "R9 irq dropped", irq, 0);

    // R10 / R3 period 5, count 1
    filt_cnt = 3'd1; filt_per = 8'd5;
    cyc(7);
    latency(1'b0, 7, "R10 latency cnt1");
    cyc(1);
    check(flag_fall == 1 && irq == 1, "R6 fall flag with irq", {flag_fall, irq}, 3);
    wr(1'b1, 2'b10);

    // R4 closed window freezes
    win_en = 0; cmp_raw = 1;
    cyc(40);
    check(cmp_filt == 0, "R4 window hold", cmp_filt, 0);
    win_en = 1;
    cyc(8);
    check(cmp_filt == 1, "R4 window reopened", cmp_filt, 1);

    // R5 count 4, period 3: a short glitch is rejected
    filt_cnt = 3'd4; filt_per = 8'd3;
    cyc(10);
    cmp_raw = 0; cyc(5); cmp_raw = 1;
    cyc(20);
    check(cmp_filt == 1, "R5 glitch rejected", cmp_filt, 1);
    latency(1'b0, 14, "R10 latency cnt4");

    // R3 period 0 acts as 1
    filt_cnt = 3'd1; filt_per = 8'd0;
    cyc(4);
    latency(1'b1, 3, "R3 period zero");

    // R7 clear in the same cycle as a new edge: flag stays set
    filt_cnt = 3'd0; cmp_raw = 0;
    cyc(6);
    wr(1'b1, 2'b11);
    cmp_raw = 1;
    cyc(3);
    wr(1'b1, 2'b01);
    check(flag_rise == 1, "R7 edge beats clear", flag_rise, 1);

    // randomized stretches checked by the model
    for (int k = 0; k < 8; k++) begin
      filt_cnt = CNT_W'(k % 5);
      filt_per = PER_W'(1 + (k * 3) % 7);
      for (int j = 0; j < 600; j++) begin
        cmp_raw = ($urandom_range(0, 9) < 2) ? ~cmp_raw : cmp_raw;
        win_en  = ($urandom_range(0, 9) != 0);
        if ($urandom_range(0, 19) == 0) begin
          reg_we = 1; reg_sel = $urandom_range(0, 1); reg_wdata = 2'($urandom_range(0, 3));
        end else begin
          reg_we = 0; reg_wdata = 0;
        end
        cyc(1);
      end
    end
    reg_we = 0;
    cyc(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule